// File: doc/BRIEF.md
# Strobe Flash Timing Controller

This block drives the trigger of a strobe lamp from an 8-bit intensity value. A value in the working range makes the lamp flash over and over. The time between flashes comes from a 256-entry period table that the value indexes, so a higher value gives faster flashing. Values near the bottom of the range switch the flashing off. At the top of the range, a mode input chooses between two behaviours: continued periodic flashing, or one single flash that is held off until the value leaves the top band.

The period counter advances once per prescaler tick, every `TICK_DIV` system clocks. Each flash is an active-low pulse of fixed length `PW_CYCLES` clocks. A periodic flash fires when the counter reaches the compare value. At that moment the compare value is reloaded from the table entry for the current value, and the counter and the prescaler both restart. A new value therefore changes the interval that follows the next compare, not the one already running. When the device address input is zero, the block runs periodically from an alternate 8-bit value (for example an analog setting) and ignores received values.

The table contents are a parameter. Its entries are `CNT_W` bits wide.

Top module: `sfc_flash_ctrl`

## Requirements
- R1: After reset `flash_n` is high, and with the address nonzero no flash occurs until a value is received.
- R2: With the address nonzero, a received value below `LO_VAL` (0x09) stops periodic flashing and clears the single-shot latch. No flash follows.
- R3: A received value that is neither below `LO_VAL` nor a single-shot value enables periodic flashing. Once running, consecutive falling edges of `flash_n` are (T[v]+1)*`TICK_DIV` clocks apart, where T[v] is table entry v. Every flash restarts the period counter and the prescaler.
- R4: With `hold_mode` low and the address nonzero, a value of `HI_VAL` (0xF7) or more stops periodic flashing. If the latch is clear, it also starts one flash: `flash_n` is low in the cycle after the one in which `chan_valid` is sampled.
- R5: While the latch is set, further single-shot values start no flash. A value outside the top band clears the latch, so a later top value fires again.
- R6: With `hold_mode` high, values of `HI_VAL` or more flash periodically like any other running value.
- R7: Each flash holds `flash_n` low for exactly `PW_CYCLES` clocks. A flash that starts during a pulse restarts the full width from its own start.
- R8: A value received during a running interval does not shorten or lengthen that interval. The new table entry applies from the next flash on.
- R9: While `dev_addr` is zero, periodic flashing is always enabled and is indexed by `alt_val`. `chan_valid` is ignored, and the received-value state seen after the address returns to nonzero is the state from before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_val | input | 8 | Received intensity value |
| chan_valid | input | 1 | One-cycle strobe: `chan_val` is new |
| hold_mode | input | 1 | Low: top band gives a single flash; high: top band flashes periodically |
| dev_addr | input | ADDR_W | Device address; zero selects the alternate source |
| alt_val | input | 8 | Alternate intensity used while the address is zero |
| flash_n | output | 1 | Active-low flash trigger pulse |

## Verification
The hardest situation to reach is a flash that starts while a pulse is already low. The width then restarts instead of adding up, and no new falling edge appears. The bench creates it by waiting for a periodic flash, then sending a single-shot value three cycles later. It predicts the rising edge from the cycle in which that update was sampled. A second hard case is showing that an update is ignored while the address is zero. The bench sends an off value in that mode, returns the address to nonzero, and checks that flashing continues at the interval of the earlier value.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [1:0] {
        LVL_OFF,
        LVL_RUN,
        LVL_TOP
    } lvl_e;

    typedef logic [31:0] tbl_t [256];

    // Default period table: idle band saturated, then roughly 1/value
    function automatic tbl_t build_tbl(input int w);
        tbl_t   t;
        longint top;
        top = (longint'(1) << w) - 1;
        for (int i = 0; i < 256; i++) begin
            if (i < 9) t[i] = 32'(top);
            else       t[i] = 32'((top * 9) / (i + 1));
        end
        return t;
    endfunction

endpackage

// File: rtl/sfc_tick_div.sv
module sfc_tick_div #(
    parameter int DIV = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (clr || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sfc_level_decode.sv
module sfc_level_decode
    import sfc_pkg::*;
#(
    parameter logic [7:0] LO_VAL = 8'h09,
    parameter logic [7:0] HI_VAL = 8'hF7
) (
    input  logic [7:0] val,
    input  logic       hold_mode,
    output lvl_e       lvl
);
    always_comb begin
        if (val < LO_VAL)                     lvl = LVL_OFF;
        else if (!hold_mode && val >= HI_VAL) lvl = LVL_TOP;
        else                                  lvl = LVL_RUN;
    end
endmodule

// File: rtl/sfc_pulse_gen.sv
module sfc_pulse_gen #(
    parameter int PW_CYCLES = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse_n
);
    localparam int PCW = $clog2(PW_CYCLES + 1);

    typedef struct packed {
        logic           low;
        logic [PCW-1:0] cnt;
    } pw_t;

    pw_t pw_d, pw_q;

    always_comb begin
        pw_d = pw_q;
        if (start) begin
            pw_d.low = 1'b1;
            pw_d.cnt = PCW'(PW_CYCLES - 1);
        end else if (pw_q.low) begin
            if (pw_q.cnt == '0) pw_d.low = 1'b0;
            else                pw_d.cnt = pw_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pw_q <= '0;
        else        pw_q <= pw_d;
    end

    assign pulse_n = !pw_q.low;
endmodule

// File: rtl/sfc_flash_ctrl.sv
module sfc_flash_ctrl
    import sfc_pkg::*;
#(
    parameter int         TICK_DIV   = 1024,
    parameter int         CNT_W      = 16,
    parameter int         PW_CYCLES  = 8192,
    parameter int         ADDR_W     = 9,
    parameter logic [7:0] LO_VAL     = 8'h09,
    parameter logic [7:0] HI_VAL     = 8'hF7,
    parameter tbl_t       PERIOD_TBL = build_tbl(CNT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        chan_val,
    input  logic              chan_valid,
    input  logic              hold_mode,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [7:0]        alt_val,
    output logic              flash_n
);
    typedef struct packed {
        logic             per_en;
        logic             lat;
        logic [7:0]       idx;
        logic [CNT_W-1:0] per_cnt;
        logic [CNT_W-1:0] cmp;
    } ctl_t;

    ctl_t s_d, s_q;

    logic tick;
    logic fire;
    logic per_fire;
    logic shot_fire;
    logic addr_zero;
    logic upd;
    logic eff_en;
    logic [7:0] sel_idx;
    lvl_e lvl;

    // Signals the bound checker observes
    logic             per_en_q;
    logic             lat_q;
    logic [CNT_W-1:0] per_cnt_q;

    assign per_en_q  = s_q.per_en;
    assign lat_q     = s_q.lat;
    assign per_cnt_q = s_q.per_cnt;

    sfc_tick_div #(.DIV(TICK_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fire),
        .tick  (tick)
    );

    sfc_level_decode #(.LO_VAL(LO_VAL), .HI_VAL(HI_VAL)) u_dec (
        .val       (chan_val),
        .hold_mode (hold_mode),
        .lvl       (lvl)
    );

    sfc_pulse_gen #(.PW_CYCLES(PW_CYCLES)) u_pw (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (fire),
        .pulse_n (flash_n)
    );

    always_comb begin
        addr_zero = (dev_addr == '0);
        upd       = chan_valid && !addr_zero;
        eff_en    = addr_zero || s_q.per_en;
        sel_idx   = addr_zero ? alt_val : s_q.idx;
        per_fire  = tick && eff_en && (s_q.per_cnt == s_q.cmp);
        shot_fire = upd && (lvl == LVL_TOP) && !s_q.lat;
        fire      = per_fire || shot_fire;

        s_d = s_q;
        if (tick)     s_d.per_cnt = s_q.per_cnt + 1'b1;
        if (per_fire) s_d.cmp     = PERIOD_TBL[sel_idx][CNT_W-1:0];
        if (fire)     s_d.per_cnt = '0;

        if (upd) begin
            s_d.idx = chan_val;
            case (lvl)
                LVL_OFF: begin s_d.per_en = 1'b0; s_d.lat = 1'b0; end
                LVL_TOP: begin s_d.per_en = 1'b0; s_d.lat = 1'b1; end
                default: begin s_d.per_en = 1'b1; s_d.lat = 1'b0; end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.cmp     <= '1;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
    parameter int         CNT_W     = 16,
    parameter int         PW_CYCLES = 8192,
    parameter int         ADDR_W    = 9,
    parameter logic [7:0] LO_VAL    = 8'h09,
    parameter logic [7:0] HI_VAL    = 8'hF7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flash_n,
    input logic              chan_valid,
    input logic [7:0]        chan_val,
    input logic              hold_mode,
    input logic [ADDR_W-1:0] dev_addr,
    input logic              per_en_q,
    input logic              lat_q,
    input logic [CNT_W-1:0]  per_cnt_q
);
    int low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_run <= 0;
        else if (!flash_n) low_run <= (low_run < 1_000_000) ? low_run + 1 : low_run;
        else               low_run <= 0;
    end

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> flash_n); // R1

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_valid && dev_addr != '0 && chan_val < LO_VAL) |=> (!per_en_q && !lat_q)); // R2

    AST_FLASH_RESTARTS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_n) |-> (per_cnt_q == '0)); // R3

    AST_TOP_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_q && chan_valid && dev_addr != '0 && !hold_mode && chan_val >= HI_VAL)
            |=> !flash_n); // R4

    AST_TOP_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q && chan_valid && dev_addr != '0 && !hold_mode && chan_val >= HI_VAL)
            |=> !$fell(flash_n)); // R5

    AST_PULSE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_n) |-> (low_run >= PW_CYCLES)); // R7
endmodule

bind sfc_flash_ctrl sfc_checker #(
    .CNT_W     (CNT_W),
    .PW_CYCLES (PW_CYCLES),
    .ADDR_W    (ADDR_W),
    .LO_VAL    (LO_VAL),
    .HI_VAL    (HI_VAL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flash_n    (flash_n),
    .chan_valid (chan_valid),
    .chan_val   (chan_val),
    .hold_mode  (hold_mode),
    .dev_addr   (dev_addr),
    .per_en_q   (per_en_q),
    .lat_q      (lat_q),
    .per_cnt_q  (per_cnt_q)
);

// File: tb/tb_sfc_flash_ctrl.sv
module tb_sfc_flash_ctrl;
    import sfc_pkg::*;

    localparam int DIV = 4;
    localparam int CW  = 8;
    localparam int PW  = 12;
    localparam int AW  = 9;

    function automatic tbl_t tb_tbl();
        tbl_t t;
        for (int i = 0; i < 256; i++)
            t[i] = (i < 9) ? 32'd255 : 32'(8 + (255 - i) / 8);
        return t;
    endfunction

    // Expected interval between falling edges for value v (R3)
    function automatic int exp_gap(input int v);
        int e;
        e = (v < 9) ? 255 : 8 + (255 - v) / 8;
        return (e + 1) * DIV;
    endfunction

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    chan_val = '0;
    logic          chan_valid = 1'b0;
    logic          hold_mode = 1'b0;
    logic [AW-1:0] dev_addr = AW'(5);
    logic [7:0]    alt_val = '0;
    logic          flash_n;

    sfc_flash_ctrl #(
        .TICK_DIV   (DIV),
        .CNT_W      (CW),
        .PW_CYCLES  (PW),
        .ADDR_W     (AW),
        .PERIOD_TBL (tb_tbl())
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_val   (chan_val),
        .chan_valid (chan_valid),
        .hold_mode  (hold_mode),
        .dev_addr   (dev_addr),
        .alt_val    (alt_val),
        .flash_n    (flash_n)
    );

    always #4 clk = ~clk; // 125 MHz

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int fall_cnt = 0;
    int last_fall = 0;
    int prev_fall = 0;
    int last_rise = 0;
    logic prev_n = 1'b1;
    logic done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Edge monitor, runs on the falling clock edge
    always @(negedge clk) begin
        if (prev_n && !flash_n) begin
            prev_fall = last_fall;
            last_fall = cyc;
            fall_cnt  = fall_cnt + 1;
        end
        if (!prev_n && flash_n) last_rise = cyc;
        prev_n = flash_n;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic send(input logic [7:0] v, output int ncyc);
        step();
        chan_val   = v;
        chan_valid = 1'b1;
        ncyc       = cyc;
        step();
        chan_valid = 1'b0;
    endtask

    task automatic wait_falls(input int n, input string req);
        int target = fall_cnt + n;
        for (int i = 0; i < 3000 && fall_cnt < target; i++) step();
        check(fall_cnt >= target, {req, " flash expected"}, fall_cnt, target);
    endtask

    task automatic wait_high();
        for (int i = 0; i < 3000 && !flash_n; i++) step();
    endtask

    task automatic t_reset();
        int f0;
        step();
        check(flash_n == 1'b1, "R1 idle level", int'(flash_n), 1);
        f0 = fall_cnt;
        repeat (2000) step();
        check(fall_cnt == f0, "R1 no flash before first value", fall_cnt, f0);
    endtask

    task automatic t_run();
        int n;
        send(8'h80, n);
        wait_falls(1, "R3");
        wait_falls(1, "R3");
        wait_falls(1, "R3");
        check(last_fall - prev_fall == exp_gap(8'h80), "R3 period 0x80",
              last_fall - prev_fall, exp_gap(8'h80));
        wait_high();
        check(last_rise - last_fall == PW, "R7 pulse width", last_rise - last_fall, PW);
    endtask

    task automatic t_change();
        int n;
        wait_falls(1, "R8");
        send(8'h10, n);
        wait_falls(1, "R8");
        check(last_fall - prev_fall == exp_gap(8'h80), "R8 running interval kept",
              last_fall - prev_fall, exp_gap(8'h80));
        wait_falls(1, "R8");
        check(last_fall - prev_fall == exp_gap(8'h10), "R8 new period applied",
              last_fall - prev_fall, exp_gap(8'h10));
    endtask

    task automatic t_off();
        int n, f0;
        send(8'h05, n);
        f0 = fall_cnt;
        repeat (1500) step();
        check(fall_cnt == f0, "R2 off value stops flashing", fall_cnt, f0);
    endtask

    task automatic t_single();
        int n, f0;
        hold_mode = 1'b0;
        send(8'hF8, n);
        check(flash_n == 1'b0 && last_fall == n + 1, "R4 single flash timing",
              last_fall, n + 1);
        f0 = fall_cnt;
        repeat (1500) step();
        check(fall_cnt == f0, "R4 no periodic after single", fall_cnt, f0);
        send(8'hFF, n);
        repeat (300) step();
        check(fall_cnt == f0, "R5 latched top value ignored", fall_cnt, f0);
        send(8'h05, n);
        send(8'hF7, n);
        check(flash_n == 1'b0 && last_fall == n + 1, "R5 re-armed after leaving band",
              last_fall, n + 1);
        f0 = fall_cnt;
        repeat (600) step();
        check(fall_cnt == f0, "R5 only one flash", fall_cnt, f0);
    endtask

    task automatic t_retrig();
        int n, f0;
        send(8'h80, n);
        wait_falls(1, "R7");
        repeat (3) step();
        f0 = fall_cnt;
        send(8'hF8, n);
        wait_high();
        check(last_rise == n + 1 + PW, "R7 width restarts on retrigger",
              last_rise, n + 1 + PW);
        check(fall_cnt == f0, "R7 no extra edge on retrigger", fall_cnt, f0);
    endtask

    task automatic t_mode_high();
        int n;
        hold_mode = 1'b1;
        send(8'hFF, n);
        wait_falls(1, "R6");
        wait_falls(1, "R6");
        wait_falls(1, "R6");
        check(last_fall - prev_fall == exp_gap(8'hFF), "R6 top value periodic",
              last_fall - prev_fall, exp_gap(8'hFF));
    endtask

    task automatic t_addr0();
        int n;
        step();
        dev_addr = '0;
        alt_val  = 8'h80;
        send(8'h05, n);
        wait_falls(1, "R9");
        wait_falls(1, "R9");
        check(last_fall - prev_fall == exp_gap(8'h80), "R9 alt value period",
              last_fall - prev_fall, exp_gap(8'h80));
        alt_val = 8'hFF;
        wait_falls(1, "R9");
        wait_falls(1, "R9");
        check(last_fall - prev_fall == exp_gap(8'hFF), "R9 alt value change",
              last_fall - prev_fall, exp_gap(8'hFF));
        dev_addr = AW'(5);
        wait_falls(1, "R9");
        wait_falls(1, "R9");
        check(last_fall - prev_fall == exp_gap(8'hFF), "R9 update ignored at address zero",
              last_fall - prev_fall, exp_gap(8'hFF));
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        t_reset();
        t_run();
        t_change();
        t_off();
        t_single();
        t_retrig();
        t_mode_high();
        t_addr0();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule